// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is an SPI slave that sits in the programmable logic and accepts fixed 16-bit command words from a host controller. The host frames each word with an active-low chip select, drives the serial clock idle-low, and holds each bit steady around the rising clock edge, where the block samples it. All three serial pins are brought into the fast system clock through two-flop synchronizers, and clock edges are found from the synchronized copy. For this to work, the system clock must run at least four times faster than the serial clock.

When the sixteenth bit of a framed word has been taken, the block splits the word into a 4-bit command code (the first four bits received) and a 12-bit value (the remaining twelve). It publishes both and pulses a single-cycle strobe. One command code, a parameter with a default of 1, loads the low 8 bits of the value into a mode configuration register. The rest of the logic reads that register to choose its operating mode. A frame that ends early leaves every output untouched. Clock edges beyond the sixteenth within a frame are also ignored.

Top module: `spi_cmd_rx`

## Requirements
- R1: While reset is held, and right after it is released, `word_strobe` is 0 and `cmd`, `data` and `conf` are all 0.
- R2: Bits arrive most-significant first. Of a 16-bit word, bits 15..12 (the first four received) appear on `cmd` and bits 11..0 appear on `data`.
- R3: A bit is taken from `mosi` only on a rising edge of `sck` while `cs_n` is low. `sck` idles low.
- R4: The sixteenth sampling edge of a frame produces exactly one `word_strobe` pulse, one system cycle wide. It appears within four system cycles of the `sck` pin edge.
- R5: `cmd` and `data` change only in the cycle in which `word_strobe` is high. Between complete words they hold their values.
- R6: A complete word whose command code equals CONF_CMD (default 4'h1) loads `data[7:0]` into `conf`. Bits 11..8 of that word have no effect on `conf`.
- R7: A complete word with any other command code leaves `conf` unchanged.
- R8: If `cs_n` goes high before 16 bits have been taken, the partial word is dropped. No strobe is issued, all outputs keep their values, and the next frame assembles from bit 0.
- R9: Rising `sck` edges after the sixteenth within the same frame are ignored. They cause no second strobe and no change to any output.
- R10: An `sck` rising edge that reaches the synchronized domain in the same cycle as `cs_n` going high is not counted.
- R11: `sck` edges while `cs_n` is high are ignored and do not disturb the bit count of the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host, MSB first |
| cs_n | input | 1 | Active-low frame select, one word per frame |
| word_strobe | output | 1 | One-cycle pulse when a word completes |
| cmd | output | 4 | Command code of the last complete word |
| data | output | 12 | Value of the last complete word |
| conf | output | 8 | Mode configuration register |

## Verification
Two things can meet in the same synchronized cycle: a bit-sampling edge of `sck` and the release of `cs_n`. The bench provokes this by shifting fifteen bits and then driving the sixteenth `sck` rise and the `cs_n` rise on the same system clock. Both therefore pass through identical synchronizer depths and arrive together. The expected outcome is that no strobe appears and `cmd`, `data` and `conf` keep their previous values. A following full word then decodes correctly, which shows that the bit count was cleared and not left at fifteen.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int DEF_WORD_W   = 16;
  localparam int DEF_CMD_W    = 4;
  localparam int DEF_CONF_W   = 8;
  localparam int DEF_SYNC_LEN = 2;
  localparam logic [DEF_CMD_W-1:0] DEF_CONF_CMD = 4'h1;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              cs_n_s,
  output logic              sample_edge,
  output logic              word_done,
  output logic [WORD_W-1:0] word_val,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(WORD_W);

  logic              sck_d;
  logic [WORD_W-2:0] shreg;

  // rising edge of the synchronized clock counts only inside a frame
  assign sample_edge = sck_s & ~sck_d & ~cs_n_s;
  assign word_done   = sample_edge && (bit_cnt == LAST_BIT);
  assign word_val    = {shreg, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sck_d <= sck_s;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sample_edge && (bit_cnt < FULL)) begin
        shreg   <= word_val[WORD_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
  parameter int WORD_W = 16,
  parameter int CMD_W  = 4,
  parameter int CONF_W = 8,
  parameter logic [CMD_W-1:0] CONF_CMD = 4'h1,
  localparam int DATA_W = WORD_W - CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_val,
  output logic              word_strobe,
  output logic [CMD_W-1:0]  cmd,
  output logic [DATA_W-1:0] data,
  output logic [CONF_W-1:0] conf
);
  function automatic logic [CMD_W-1:0] code_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: CMD_W];
  endfunction

  function automatic logic [DATA_W-1:0] value_of(input logic [WORD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  function automatic logic [CONF_W-1:0] conf_of(input logic [DATA_W-1:0] v);
    return v[CONF_W-1:0];
  endfunction

  logic conf_hit;
  assign conf_hit = word_done && (code_of(word_val) == CONF_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_strobe <= 1'b0;
      cmd         <= '0;
      data        <= '0;
      conf        <= '0;
    end else begin
      word_strobe <= word_done;
      if (word_done) begin
        cmd  <= code_of(word_val);
        data <= value_of(word_val);
      end
      if (conf_hit) conf <= conf_of(value_of(word_val));
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int CMD_W    = DEF_CMD_W,
  parameter int CONF_W   = DEF_CONF_W,
  parameter int SYNC_LEN = DEF_SYNC_LEN,
  parameter logic [CMD_W-1:0] CONF_CMD = DEF_CONF_CMD,
  localparam int DATA_W = WORD_W - CMD_W,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              word_strobe,
  output logic [CMD_W-1:0]  cmd,
  output logic [DATA_W-1:0] data,
  output logic [CONF_W-1:0] conf
);
  logic              sck_s, mosi_s, cs_n_s;
  logic              sample_edge;
  logic              word_done;
  logic [WORD_W-1:0] word_val;
  logic [CNT_W-1:0]  bit_cnt;

  spi_cmd_sync #(
    .W(3), .STAGES(SYNC_LEN), .RST_VAL(3'b001)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sck, mosi, cs_n}),
    .dout ({sck_s, mosi_s, cs_n_s})
  );

  spi_cmd_frame #(.WORD_W(WORD_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (sck_s),
    .mosi_s     (mosi_s),
    .cs_n_s     (cs_n_s),
    .sample_edge(sample_edge),
    .word_done  (word_done),
    .word_val   (word_val),
    .bit_cnt    (bit_cnt)
  );

  spi_cmd_decode #(
    .WORD_W(WORD_W), .CMD_W(CMD_W), .CONF_W(CONF_W), .CONF_CMD(CONF_CMD)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_done  (word_done),
    .word_val   (word_val),
    .word_strobe(word_strobe),
    .cmd        (cmd),
    .data       (data),
    .conf       (conf)
  );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk #(
  parameter int WORD_W = 16,
  parameter int CMD_W  = 4,
  parameter int CONF_W = 8,
  parameter logic [CMD_W-1:0] CONF_CMD = 4'h1,
  localparam int DATA_W = WORD_W - CMD_W,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_s,
  input logic              sample_edge,
  input logic              word_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              word_strobe,
  input logic [CMD_W-1:0]  cmd,
  input logic [DATA_W-1:0] data,
  input logic [CONF_W-1:0] conf
);
  // R4
  done_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> word_strobe);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |=> !word_strobe);

  // R5
  hold_between_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_strobe |-> ($stable(cmd) && $stable(data)));

  // R6
  conf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_strobe && cmd == CONF_CMD) |-> (conf == data[CONF_W-1:0]));

  // R7
  conf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_strobe || cmd != CONF_CMD) |-> $stable(conf));

  // R10
  no_edge_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> (!sample_edge && !word_done));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));

  // R8
  count_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_cnt == '0));
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(
  .WORD_W(WORD_W), .CMD_W(CMD_W), .CONF_W(CONF_W), .CONF_CMD(CONF_CMD)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_s     (cs_n_s),
  .sample_edge(sample_edge),
  .word_done  (word_done),
  .bit_cnt    (bit_cnt),
  .word_strobe(word_strobe),
  .cmd        (cmd),
  .data       (data),
  .conf       (conf)
);

// File: tb/test_spi_cmd_rx.sv
module test_spi_cmd_rx;
  localparam int CLK_P = 10;
  localparam int HALF  = 3;
  localparam int NVEC  = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h10A5, 16'h3ABC, 16'h1F5A, 16'h0000,
    16'hFFFF, 16'h1000, 16'h8001, 16'h10C3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic        word_strobe;
  logic [3:0]  cmd;
  logic [11:0] data;
  logic [7:0]  conf;

  int n_chk = 0, n_fail = 0, n_strobe = 0;
  bit prev_strobe = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_conf = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  spi_cmd_rx i_spi_cmd_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .word_strobe(word_strobe), .cmd(cmd), .data(data), .conf(conf)
  );

  // R4: count strobe pulses and flag any wider than one cycle
  always @(negedge clk) begin
    if (word_strobe) n_strobe++;
    if (word_strobe && prev_strobe) begin
      n_chk++; n_fail++;
      $display("FAIL R4: strobe width actual >1 expected 1");
    end
    prev_strobe = word_strobe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    mosi = b; wait_clk(HALF);
    sck = 1'b1; wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input int extra);
    cs_n = 1'b0; wait_clk(HALF);
    for (int i = 0; i < nbits; i++) pulse(w[15-i]);
    for (int i = 0; i < extra; i++) pulse(1'b0);
    wait_clk(HALF);
    cs_n = 1'b1; wait_clk(8);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s0;
    logic [3:0] pc;
    logic [11:0] pd;
    wait_clk(3);
    // R1: outputs during reset
    chk("R1 strobe", word_strobe, 0);
    chk("R1 cmd", cmd, 0);
    chk("R1 data", data, 0);
    chk("R1 conf", conf, 0);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R1 conf after release", conf, 0);

    // R2 R3 R4 R6 R7: table of words
    for (int v = 0; v < NVEC; v++) begin
      s0 = n_strobe;
      frame(VEC[v], 16, 0);
      if (VEC[v][15:12] == 4'h1) exp_conf = VEC[v][7:0];
      chk("R4 one strobe per word", n_strobe - s0, 1);
      chk("R2 cmd", cmd, VEC[v][15:12]);
      chk("R2 data", data, VEC[v][11:0]);
      chk("R6/R7 conf", conf, exp_conf);
    end

    // R5: outputs hold while idle
    wait_clk(40);
    chk("R5 cmd held", cmd, 4'h1);
    chk("R5 data held", data, 12'h0C3);

    // R8: partial frame dropped, next frame starts fresh
    s0 = n_strobe;
    frame(16'hFFFF, 7, 0);
    chk("R8 no strobe", n_strobe - s0, 0);
    chk("R8 cmd kept", cmd, 4'h1);
    chk("R8 data kept", data, 12'h0C3);
    frame(16'h10E7, 16, 0);
    exp_conf = 8'hE7;
    chk("R8 fresh word conf", conf, exp_conf);

    // R9: extra edges after the sixteenth
    s0 = n_strobe;
    frame(16'h4321, 16, 5);
    chk("R9 single strobe", n_strobe - s0, 1);
    chk("R9 cmd", cmd, 4'h4);
    chk("R9 data", data, 12'h321);

    // R10: sixteenth edge together with cs_n release
    s0 = n_strobe;
    cs_n = 1'b0; wait_clk(HALF);
    for (int i = 0; i < 15; i++) pulse(1'b1);
    mosi = 1'b1; wait_clk(HALF);
    sck = 1'b1; cs_n = 1'b1; wait_clk(HALF);
    sck = 1'b0; wait_clk(8);
    chk("R10 no strobe", n_strobe - s0, 0);
    chk("R10 cmd kept", cmd, 4'h4);
    chk("R10 conf kept", conf, exp_conf);
    frame(16'h1055, 16, 0);
    exp_conf = 8'h55;
    chk("R10 next word conf", conf, exp_conf);

    // R11: clock edges while deselected are ignored
    s0 = n_strobe;
    for (int i = 0; i < 5; i++) pulse(1'b1);
    wait_clk(8);
    chk("R11 no strobe when deselected", n_strobe - s0, 0);
    frame(16'h2123, 16, 0);
    chk("R11 cmd", cmd, 4'h2);
    chk("R11 data", data, 12'h123);
    chk("R11 conf", conf, exp_conf);

    pc = cmd; pd = data;
    chk("R5 final hold cmd", cmd, pc);
    chk("R5 final hold data", data, pd);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule